// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block models the column-access engine of one synchronous DRAM bank, seen from the device side. A mode word sets the burst length, the wrap ordering (sequential or interleaved) and the read latency (2 or 3 clocks). READ and WRITE commands each carry a start column. From that column the block steps through the beats of the burst and reports the column used on every beat. Writes go into an internal 256-word array with per-byte masks. Reads come back through a latency pipeline with per-byte output enables.

A burst ends when its length runs out or when a terminate command arrives. A new READ or WRITE on any cycle drops the old burst and starts again at the new column. A full-page burst (sequential only) keeps going across all 256 columns until it is stopped. Read beats that entered the latency pipeline before a stop still come out.

Top module: `sdr_col_seq`

## Requirements
- R1: After reset no beat is active (`beat_act`=0) and both read byte-valid flags are 0. The mode after reset is 1-beat sequential with latency 2.
- R2: Sequential ordering. A burst of length L (a power of two) keeps the column bits above the low log2(L) bits fixed. It adds the beat index to the low bits modulo L. Example: length 4 from column 6 gives 6,7,4,5.
- R3: Interleaved ordering (`mode_ilv`=1). Beat b uses column start XOR b. Example: length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: `mode_len`=3'b111 with sequential ordering is a full-page burst. The column goes up by one each cycle, wraps from 255 to 0, and does not stop by itself.
- R5: `mode_len` codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. The reserved codes 100 to 110 give 1 beat. `beat_act` falls in the cycle after the last beat.
- R6: `mode_len`=3'b111 together with interleaved ordering is treated as an 8-beat interleaved burst.
- R7: A terminate command (`cmd`=2'b11) performs no beat in its own cycle or in any cycle after it.
- R8: A READ (`cmd`=2'b01) or WRITE (`cmd`=2'b10) on any cycle, even during a burst, performs its first beat at its own start column in that same cycle.
- R9: A write beat stores `wdata` in the beat's column in that same cycle. Where `dmask` bit 1 is set the upper byte is left unchanged, and where bit 0 is set the lower byte is left unchanged.
- R10: Data for a read beat sampled at edge E appears on `rdata` in time to be sampled at edge E+2 (`mode_lat3`=0) or edge E+3 (`mode_lat3`=1), with `rvalid` set.
- R11: A `dmask` bit sampled at edge M clears the matching `rvalid` bit as seen at edge M+2, whatever the latency.
- R12: Read beats performed before a terminate or an interrupting command still come out at their normal latency.
- R13: Mode fields are captured when `mode_load`=1 and apply from the next command onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Capture the mode fields |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 selects interleaved ordering |
| mode_lat3 | input | 1 | 1 selects read latency 3, 0 selects latency 2 |
| cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 terminate |
| col | input | 8 | Start column for read or write |
| wdata | input | 16 | Write data for the current beat |
| dmask | input | 2 | Byte masks: bit 1 upper byte, bit 0 lower byte |
| beat_act | output | 1 | A beat was performed at the last edge |
| beat_col | output | 8 | Column of that beat |
| rdata | output | 16 | Read data |
| rvalid | output | 2 | Per-byte read valid (bit 1 upper byte) |

## Verification
Some properties are checked by assertions on every cycle:
- a restart always lands on the commanded column;
- a terminate always silences the next cycle;
- a continuing burst never leaves its aligned block;
- valid read data always follows a read beat by the programmed latency;
- a masked byte is never flagged valid two clocks later;
- the reserved interleaved full-page code is folded to eight beats.

Other behaviour can only be shown by the bench's scenarios. These are the exact column orders for each length and ordering, full-page wrap past column 255, the stored result of masked writes, and read data that still drains out of the pipeline after a stop.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_TERM  = 2'b11
    } cmd_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    input  logic             lat3_i,
    output logic [COL_W-1:0] len_mask_o,
    output logic             full_o,
    output logic             ilv_o,
    output logic             lat3_o
);
    typedef struct packed {
        logic [COL_W-1:0] msk;
        logic             full;
        logic             ilv;
        logic             lat3;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load_i) begin
            mode_d.ilv  = ilv_i;
            mode_d.lat3 = lat3_i;
            mode_d.full = 1'b0;
            case (len_i)
                3'd0:    mode_d.msk = COL_W'(0);
                3'd1:    mode_d.msk = COL_W'(1);
                3'd2:    mode_d.msk = COL_W'(3);
                3'd3:    mode_d.msk = COL_W'(7);
                3'd7: begin
                    // interleaved full page is reserved: fold to 8 beats
                    mode_d.msk  = ilv_i ? COL_W'(7) : '1;
                    mode_d.full = !ilv_i;
                end
                default: mode_d.msk = COL_W'(0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign len_mask_o = mode_q.msk;
    assign full_o     = mode_q.full;
    assign ilv_o      = mode_q.ilv;
    assign lat3_o     = mode_q.lat3;

    a_r6_ilv_full_folds: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i == 3'd7 && ilv_i) |=> (!full_o && len_mask_o == COL_W'(7)));
endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] len_mask_i,
    input  logic             full_i,
    input  logic             ilv_i,
    output logic             fire_o,
    output logic             fire_rd_o,
    output logic [COL_W-1:0] fire_col_o,
    output logic             beat_act_o,
    output logic [COL_W-1:0] beat_col_o
);
    import sdr_col_pkg::*;

    typedef struct packed {
        logic             act;
        logic             rd;
        logic             ilv;
        logic             full;
        logic [COL_W-1:0] msk;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
        logic             bact;
        logic [COL_W-1:0] bcol;
    } burst_t;

    burst_t st_d, st_q;
    cmd_e   cmd_c;
    logic   fire_c, fire_rd_c;
    logic [COL_W-1:0] fire_col_c, seq_col_c, ilv_col_c;

    always_comb begin
        cmd_c      = cmd_e'(cmd_i);
        seq_col_c  = (st_q.start & ~st_q.msk) | ((st_q.start + st_q.cnt) & st_q.msk);
        ilv_col_c  = st_q.start ^ st_q.cnt;
        st_d       = st_q;
        fire_c     = 1'b0;
        fire_rd_c  = st_q.rd;
        fire_col_c = st_q.start;
        case (cmd_c)
            CMD_READ, CMD_WRITE: begin
                fire_c     = 1'b1;
                fire_rd_c  = (cmd_c == CMD_READ);
                fire_col_c = col_i;
                st_d.act   = full_i || (len_mask_i != '0);
                st_d.rd    = fire_rd_c;
                st_d.ilv   = ilv_i;
                st_d.full  = full_i;
                st_d.msk   = len_mask_i;
                st_d.start = col_i;
                st_d.cnt   = COL_W'(1);
            end
            CMD_TERM: st_d.act = 1'b0;
            default: begin
                if (st_q.act) begin
                    fire_c     = 1'b1;
                    fire_col_c = st_q.ilv ? ilv_col_c : seq_col_c;
                    st_d.cnt   = st_q.cnt + COL_W'(1);
                    if (!st_q.full && st_q.cnt == st_q.msk) st_d.act = 1'b0;
                end
            end
        endcase
        st_d.bact = fire_c;
        if (fire_c) st_d.bcol = fire_col_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o     = fire_c;
    assign fire_rd_o  = fire_rd_c;
    assign fire_col_o = fire_col_c;
    assign beat_act_o = st_q.bact;
    assign beat_col_o = st_q.bcol;

    a_r8_restart_at_col: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b01 || cmd_i == 2'b10) |=> (beat_act_o && beat_col_o == $past(col_i)));

    a_r7_term_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b11) |=> !beat_act_o);

    // R2 and R3: a continuing burst stays inside its aligned block
    a_r2_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_act_o && $past(beat_act_o) && $past(cmd_i) == 2'b00)
        |-> (((beat_col_o ^ $past(beat_col_o)) & ~st_q.msk) == '0));
endmodule

// File: rtl/sdr_word_array.sv
module sdr_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W/8-1:0] bmask_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = DATA_W / 8;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we_i && !bmask_i[g]) lane_mem[addr_i] <= wdata_i[g*8 +: 8];
        end
        assign rdata_o[g*8 +: 8] = lane_mem[addr_i];
    end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int DATA_W   = 16,
    parameter int MAX_LAT  = 3,
    parameter int MASK_DLY = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [DATA_W/8-1:0] mask_i,
    input  logic                lat3_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W/8-1:0] rvalid_o
);
    localparam int NB = DATA_W / 8;

    typedef struct packed {
        logic [MAX_LAT-1:0]             vld;
        logic [MAX_LAT-1:0][DATA_W-1:0] dat;
        logic [MASK_DLY-1:0][NB-1:0]    mk;
    } pipe_t;

    pipe_t pp_d, pp_q;
    int    tap_c;

    always_comb begin
        pp_d        = pp_q;
        pp_d.vld[0] = fire_i;
        pp_d.dat[0] = data_i;
        pp_d.mk[0]  = mask_i;
        for (int i = 1; i < MAX_LAT; i++) begin
            pp_d.vld[i] = pp_q.vld[i-1];
            pp_d.dat[i] = pp_q.dat[i-1];
        end
        for (int i = 1; i < MASK_DLY; i++) pp_d.mk[i] = pp_q.mk[i-1];
        tap_c = lat3_i ? 2 : 1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign rdata_o = pp_q.dat[tap_c];
    for (genvar g = 0; g < NB; g++) begin : g_vld
        assign rvalid_o[g] = pp_q.vld[tap_c] & ~pp_q.mk[MASK_DLY-1][g];

        a_r11_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid_o[g] |-> !$past(mask_i[g], 2));
    end

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (|rvalid_o) |-> (lat3_i ? $past(fire_i, 3) : $past(fire_i, 2)));
endmodule

// File: rtl/sdr_col_seq.sv
module sdr_col_seq #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_load,
    input  logic [2:0]          mode_len,
    input  logic                mode_ilv,
    input  logic                mode_lat3,
    input  logic [1:0]          cmd,
    input  logic [COL_W-1:0]    col,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] dmask,
    output logic                beat_act,
    output logic [COL_W-1:0]    beat_col,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W/8-1:0] rvalid
);
    localparam int NB = DATA_W / 8;

    logic [COL_W-1:0]  len_mask_w, fire_col_w;
    logic              full_w, ilv_w, lat3_w, fire_w, fire_rd_w;
    logic [DATA_W-1:0] arr_rd_w;

    sdr_mode_reg #(.COL_W(COL_W)) i_mode (
        .clk(clk), .rst_n(rst_n), .load_i(mode_load), .len_i(mode_len),
        .ilv_i(mode_ilv), .lat3_i(mode_lat3), .len_mask_o(len_mask_w),
        .full_o(full_w), .ilv_o(ilv_w), .lat3_o(lat3_w)
    );

    sdr_burst_ctl #(.COL_W(COL_W)) i_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col),
        .len_mask_i(len_mask_w), .full_i(full_w), .ilv_i(ilv_w),
        .fire_o(fire_w), .fire_rd_o(fire_rd_w), .fire_col_o(fire_col_w),
        .beat_act_o(beat_act), .beat_col_o(beat_col)
    );

    sdr_word_array #(.ADDR_W(COL_W), .DATA_W(DATA_W)) i_arr (
        .clk(clk), .we_i(fire_w && !fire_rd_w), .addr_i(fire_col_w),
        .wdata_i(wdata), .bmask_i(dmask), .rdata_o(arr_rd_w)
    );

    sdr_rd_pipe #(.DATA_W(DATA_W), .MAX_LAT(3), .MASK_DLY(2)) i_pipe (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_w && fire_rd_w),
        .data_i(arr_rd_w), .mask_i(dmask), .lat3_i(lat3_w),
        .rdata_o(rdata), .rvalid_o(rvalid)
    );

    initial begin
        a_r9_byte_lanes: assert (NB * 8 == DATA_W);
    end
endmodule

// File: tb/test_sdr_col_seq.sv
`timescale 1ns/1ps
module test_sdr_col_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [2:0]  mode_len = '0;
    logic        mode_ilv = 1'b0;
    logic        mode_lat3 = 1'b0;
    logic [1:0]  cmd = '0;
    logic [7:0]  col = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  dmask = '0;
    logic        beat_act;
    logic [7:0]  beat_col;
    logic [15:0] rdata;
    logic [1:0]  rvalid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdr_col_seq i_sdr_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_lat3(mode_lat3), .cmd(cmd), .col(col),
        .wdata(wdata), .dmask(dmask), .beat_act(beat_act), .beat_col(beat_col),
        .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct packed {
        logic [2:0]  len;
        logic        ilv;
        logic [7:0]  start;
        logic [3:0]  n;
        logic [63:0] cols;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd2, 1'b0, 8'h06, 4'd4, 64'h0607040500000000},  // R2
        '{3'd3, 1'b1, 8'h05, 4'd8, 64'h0504070601000302},  // R3
        '{3'd3, 1'b0, 8'h1D, 4'd8, 64'h1D1E1F18191A1B1C},  // R2
        '{3'd1, 1'b0, 8'h09, 4'd2, 64'h0908000000000000},  // R5
        '{3'd0, 1'b0, 8'h33, 4'd1, 64'h3300000000000000},  // R5
        '{3'd5, 1'b0, 8'h40, 4'd1, 64'h4000000000000000},  // R5 reserved
        '{3'd7, 1'b1, 8'h12, 4'd8, 64'h1213101116171415},  // R6
        '{3'd2, 1'b1, 8'h02, 4'd4, 64'h0203000100000000}   // R3
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d, input logic [1:0] m);
        cmd = c; col = a; wdata = d; dmask = m;
    endtask

    task automatic load_mode(input logic [2:0] len, input logic ilv, input logic lat3);
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        mode_load = 1'b1; mode_len = len; mode_ilv = ilv; mode_lat3 = lat3;
        tick();
        mode_load = 1'b0;
    endtask

    function automatic logic [15:0] pat(input logic [7:0] c);
        return {c, ~c};
    endfunction

    task automatic chk_beat(input logic [7:0] exp, input string req);
        chk(beat_act === 1'b1 && beat_col === exp, req, {23'd0, beat_act, beat_col}, {24'd1, exp});
    endtask

    task automatic chk_rd(input logic [15:0] exp, input string req);
        chk(rvalid === 2'b11 && rdata === exp, req, {14'd0, rvalid, rdata}, {14'd0, 2'b11, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(beat_act === 1'b0, "R1 beat_act", {31'd0, beat_act}, 32'd0);
        chk(rvalid === 2'b00, "R1 rvalid", {30'd0, rvalid}, 32'd0);
        // R1: default mode is 1 beat
        drive(2'b10, 8'hA0, pat(8'hA0), 2'b00);
        tick();
        chk_beat(8'hA0, "R1 default single beat");
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick();
        chk(beat_act === 1'b0, "R1 default length 1", {31'd0, beat_act}, 32'd0);

        // vector walk: burst orderings and lengths (R2 R3 R5 R6 R13)
        for (int v = 0; v < 8; v++) begin
            load_mode(VECS[v].len, VECS[v].ilv, 1'b0);
            for (int b = 0; b < int'(VECS[v].n); b++) begin
                logic [7:0] e;
                e = VECS[v].cols[(7-b)*8 +: 8];
                drive(b == 0 ? 2'b10 : 2'b00, VECS[v].start, pat(e), 2'b00);
                tick();
                chk_beat(e, $sformatf("R2/R3/R5/R6/R13 vec%0d beat%0d", v, b));
            end
            drive(2'b00, 8'h00, 16'h0000, 2'b00);
            tick();
            chk(beat_act === 1'b0, $sformatf("R5 vec%0d burst end", v), {31'd0, beat_act}, 32'd0);
        end

        // R10: latency 2, length 4 from column 6
        load_mode(3'd2, 1'b0, 1'b0);
        drive(2'b01, 8'h06, 16'h0000, 2'b00);
        tick();
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        chk(rvalid === 2'b00, "R10 lat2 not early", {30'd0, rvalid}, 32'd0);
        tick(); chk_rd(pat(8'h06), "R10 lat2 beat0");
        tick(); chk_rd(pat(8'h07), "R10 lat2 beat1");
        tick(); chk_rd(pat(8'h04), "R10 lat2 beat2");
        tick(); chk_rd(pat(8'h05), "R10 lat2 beat3");
        tick(); chk(rvalid === 2'b00, "R10 lat2 end", {30'd0, rvalid}, 32'd0);

        // R10: latency 3
        load_mode(3'd2, 1'b0, 1'b1);
        drive(2'b01, 8'h06, 16'h0000, 2'b00);
        tick();
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick(); chk(rvalid === 2'b00, "R10 lat3 not early", {30'd0, rvalid}, 32'd0);
        tick(); chk_rd(pat(8'h06), "R10 lat3 beat0");
        tick(); chk_rd(pat(8'h07), "R10 lat3 beat1");

        // R4 full page wrap, then R7 terminate
        repeat (4) tick();
        load_mode(3'd7, 1'b0, 1'b0);
        for (int b = 0; b < 12; b++) begin
            logic [7:0] e;
            e = 8'hFE + 8'(b);
            drive(b == 0 ? 2'b10 : 2'b00, 8'hFE, pat(e), 2'b00);
            tick();
            chk_beat(e, $sformatf("R4 full page beat%0d", b));
        end
        drive(2'b11, 8'h00, 16'h0000, 2'b00);
        tick();
        chk(beat_act === 1'b0, "R7 term cycle", {31'd0, beat_act}, 32'd0);
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick();
        chk(beat_act === 1'b0, "R7 after term", {31'd0, beat_act}, 32'd0);

        // R8 interrupt: 8-beat burst at 0x20 replaced by one at 0x55
        load_mode(3'd3, 1'b0, 1'b0);
        for (int b = 0; b < 3; b++) begin
            drive(b == 0 ? 2'b10 : 2'b00, 8'h20, pat(8'h20 + 8'(b)), 2'b00);
            tick();
        end
        begin
            logic [63:0] nc;
            nc = 64'h5556575051525354;
            for (int b = 0; b < 8; b++) begin
                drive(b == 0 ? 2'b10 : 2'b00, 8'h55, pat(nc[(7-b)*8 +: 8]), 2'b00);
                tick();
                chk_beat(nc[(7-b)*8 +: 8], $sformatf("R8 new burst beat%0d", b));
            end
        end
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick();
        chk(beat_act === 1'b0, "R8 new burst ends", {31'd0, beat_act}, 32'd0);

        // R9 byte-masked writes to column 0x80
        load_mode(3'd0, 1'b0, 1'b0);
        drive(2'b10, 8'h80, 16'h1234, 2'b00); tick();
        drive(2'b10, 8'h80, 16'hABCD, 2'b10); tick();
        drive(2'b10, 8'h80, 16'h5678, 2'b01); tick();
        drive(2'b10, 8'h80, 16'hFFFF, 2'b11); tick();
        drive(2'b01, 8'h80, 16'h0000, 2'b00); tick();
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick(); chk_rd(16'h56CD, "R9 masked write result");

        // R11 read byte mask
        drive(2'b01, 8'h80, 16'h0000, 2'b01); tick();
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick();
        chk(rvalid === 2'b10 && rdata[15:8] === 8'h56, "R11 lower byte hidden", {14'd0, rvalid, rdata}, {14'd0, 2'b10, 16'h56CD});
        tick();
        chk(rvalid === 2'b00, "R11 after masked beat", {30'd0, rvalid}, 32'd0);

        // R12 drain after terminate, latency 3
        load_mode(3'd3, 1'b0, 1'b1);
        drive(2'b01, 8'h18, 16'h0000, 2'b00); tick();
        drive(2'b00, 8'h00, 16'h0000, 2'b00); tick();
        drive(2'b11, 8'h00, 16'h0000, 2'b00); tick();
        chk(beat_act === 1'b0, "R7 term stops read", {31'd0, beat_act}, 32'd0);
        chk_rd(pat(8'h18), "R12 drain beat0");
        drive(2'b00, 8'h00, 16'h0000, 2'b00);
        tick(); chk_rd(pat(8'h19), "R12 drain beat1");
        tick(); chk(rvalid === 2'b00, "R12 drain ends", {30'd0, rvalid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule